// File: doc/BRIEF.md
# Embedded-Sync 16-bit YCbCr Stream Decoder

This block accepts a 4:2:2 YCbCr video stream on a 16-bit bus, one word per clock qualified by a valid strobe. The upper byte of each word carries a luma sample. The lower byte carries a chroma sample, and chroma alternates between Cb and Cr from word to word. The stream has no separate sync pins. Horizontal and vertical timing travel inside the data as two-word reference codes. The first code word is a marker. The second code word carries a status byte with the field, vertical-blanking and end/start-of-active-video flags.

The decoder holds each word for one accepted word so that it can tell a marker from pixel data. It removes the two code words from the pixel stream. It emits the other words as separated luma and chroma with a tag that marks a Cr sample. It also keeps registered field, vertical-blank and active-video flags, and gives a one-cycle pulse on every end-of-active-video code. A marker that is not followed by a valid status word passes through as ordinary pixels. A code found on a Cr slot sets a sticky error flag.

Top module: `ycc_sync_decoder`

## Requirements
- R1: Each accepted non-code word is emitted one accepted word later. `out_valid` is high for one cycle, `out_luma` holds bits [15:8] and `out_chroma` holds bits [7:0] of that word. Idle cycles with `in_valid` low stall the held word.
- R2: `out_is_cr` tags the chroma phase. 0 means Cb and 1 means Cr. The phase toggles on every accepted word, code words included. The first word after a code is always Cb.
- R3: A code is a word of 0x00FF followed by an accepted word whose lower byte is 0x00. Neither of the two words ever produces `out_valid`.
- R4: Status bit 6 sets `out_field` (1 = second field). The flag changes only in the cycle after a code is decoded.
- R5: Status bit 5 sets `out_vblank` (1 = field blanking). The flag is updated on each code.
- R6: A code with status bit 4 = 1 (end of active video) clears `out_active` and raises `out_hs` for exactly one cycle.
- R7: A code with status bit 4 = 0 (start of active video) sets `out_active` to the inverse of status bit 5.
- R8: Status bit 7 and bits 3..0 have no effect on any output.
- R9: A 0x00FF word followed by a word whose lower byte is not 0x00 is emitted as two ordinary pixels.
- R10: `out_err` becomes 1 when a code's first word falls on a Cr slot. It stays at 1 until reset.
- R11: While `rst_n` is low at a clock edge, every output is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | 16 | Luma [15:8], chroma [7:0] or code word |
| out_valid | output | 1 | Pixel output strobe |
| out_luma | output | 8 | Luma sample |
| out_chroma | output | 8 | Chroma sample |
| out_is_cr | output | 1 | 1 = chroma is Cr, 0 = Cb |
| out_active | output | 1 | Active-video flag |
| out_field | output | 1 | Field flag |
| out_vblank | output | 1 | Vertical-blanking flag |
| out_hs | output | 1 | One-cycle pulse on end-of-active code |
| out_err | output | 1 | Sticky code-phase error |

## Verification
The bench builds the block with the default 8-bit component width. With that width the status flags sit at bits 6, 5 and 4, so the codes it sends can set the ignored bits 7 and 3..0 to one while the flags of interest vary. This width also puts byte-wise patterns within reach: a marker-shaped pixel followed by a non-zero chroma byte, a gap in the valid strobe while a word is held, and a code placed on a Cr slot. In every case the scoreboard tracks phase and flags with its own model.

// File: rtl/ycc_pkg.sv
// Package: shared types for the embedded-sync YCbCr decoder.
// Assumes the status flags keep fixed offsets from the top of the upper byte.
package ycc_pkg;
    typedef struct packed {
        logic f;   // field 2 when set
        logic v;   // vertical blanking when set
        logic h;   // end of active video when set
    } ycc_flags_t;
endpackage

// File: rtl/ycc_code_match.sv
// Module: recognises a two-word timing code from the held word and the
// incoming word, and pulls out the three flags of the status byte.
// Assumes the caller presents the held word only while hold_vld is high.
module ycc_code_match #(
    parameter int DW = 8
) (
    input  logic            hold_vld,
    input  logic [2*DW-1:0] hold_word,
    input  logic            in_valid,
    input  logic [2*DW-1:0] in_word,
    output logic            code_hit,
    output ycc_pkg::ycc_flags_t flags
);
    localparam int F_POS = DW - 2;
    localparam int V_POS = DW - 3;
    localparam int H_POS = DW - 4;

    logic marker_ok;
    logic status_ok;

    // Marker: zero upper byte and all-ones lower byte; status: zero lower byte.
    always_comb begin
        marker_ok = hold_vld && (hold_word[2*DW-1:DW] == '0) && (&hold_word[DW-1:0]);
        status_ok = in_valid && (in_word[DW-1:0] == '0);
        code_hit  = marker_ok && status_ok;
        flags.f   = in_word[DW + F_POS];
        flags.v   = in_word[DW + V_POS];
        flags.h   = in_word[DW + H_POS];
    end
endmodule

// File: rtl/ycc_phase_track.sv
// Module: keeps the chroma phase of the held word and of the next word.
// Assumes every accepted word fills one slot and that a code resets the
// following slot to the Cb phase.
module ycc_phase_track (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic code_hit,
    output logic hold_cr
);
    logic nxt_cr;

    // Advance the phase per accepted word; realign to Cb after a code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_cr  <= 1'b0;
            hold_cr <= 1'b0;
        end else if (in_valid) begin
            if (code_hit) begin
                nxt_cr <= 1'b0;
            end else begin
                hold_cr <= nxt_cr;
                nxt_cr  <= ~nxt_cr;
            end
        end
    end
endmodule

// File: rtl/ycc_sync_flags.sv
// Module: registered timing flags updated only on a decoded code, plus the
// end-of-active pulse and the sticky phase error.
// Assumes code_hit is at most one cycle wide per code.
module ycc_sync_flags (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                code_hit,
    input  ycc_pkg::ycc_flags_t flags,
    input  logic                hold_cr,
    output logic                field,
    output logic                vblank,
    output logic                active,
    output logic                hs,
    output logic                err
);
    // Latch the flags on a code, pulse hs on end-of-active, record bad phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field  <= 1'b0;
            vblank <= 1'b0;
            active <= 1'b0;
            hs     <= 1'b0;
            err    <= 1'b0;
        end else begin
            hs <= 1'b0;
            if (code_hit) begin
                field  <= flags.f;
                vblank <= flags.v;
                if (flags.h) begin
                    active <= 1'b0;
                    hs     <= 1'b1;
                end else begin
                    active <= ~flags.v;
                end
                if (hold_cr) err <= 1'b1;
            end
        end
    end

    // R4
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !code_hit |=> $stable(field));
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R7
    sav_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_hit && !flags.h && !flags.v) |=> active);
endmodule

// File: rtl/ycc_sync_decoder.sv
// Module: top of the embedded-sync 16-bit YCbCr decoder. Holds one word to
// tell markers from pixels, drops code words, splits luma and chroma.
// Assumes luma on the upper byte, chroma on the lower byte.
module ycc_sync_decoder #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2*DW-1:0] in_word,
    output logic            out_valid,
    output logic [DW-1:0]   out_luma,
    output logic [DW-1:0]   out_chroma,
    output logic            out_is_cr,
    output logic            out_active,
    output logic            out_field,
    output logic            out_vblank,
    output logic            out_hs,
    output logic            out_err
);
    localparam int WW = 2 * DW;

    logic                hold_vld;
    logic [WW-1:0]       hold_word;
    logic                hold_cr;
    logic                code_hit;
    ycc_pkg::ycc_flags_t flags;

    ycc_code_match #(.DW(DW)) u_match (
        .hold_vld (hold_vld),
        .hold_word(hold_word),
        .in_valid (in_valid),
        .in_word  (in_word),
        .code_hit (code_hit),
        .flags    (flags)
    );

    ycc_phase_track u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .code_hit(code_hit),
        .hold_cr (hold_cr)
    );

    ycc_sync_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_hit(code_hit),
        .flags   (flags),
        .hold_cr (hold_cr),
        .field   (out_field),
        .vblank  (out_vblank),
        .active  (out_active),
        .hs      (out_hs),
        .err     (out_err)
    );

    // Hold stage: keep one word back, drop it when it turns out to be a marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_word <= '0;
        end else if (in_valid) begin
            if (code_hit) begin
                hold_vld <= 1'b0;
            end else begin
                hold_vld  <= 1'b1;
                hold_word <= in_word;
            end
        end
    end

    // Output stage: release the held word as a pixel when the next word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_luma   <= '0;
            out_chroma <= '0;
            out_is_cr  <= 1'b0;
        end else begin
            out_valid <= in_valid && hold_vld && !code_hit;
            if (in_valid && hold_vld && !code_hit) begin
                out_luma   <= hold_word[WW-1:DW];
                out_chroma <= hold_word[DW-1:0];
                out_is_cr  <= hold_cr;
            end
        end
    end

    // R3
    code_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_hit |=> !out_valid);
    // R6
    hs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hs |=> !out_hs);
    // R6
    eav_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_hit && flags.h) |=> (!out_active && out_hs));
endmodule

// File: tb/ycc_sync_decoder_test.sv
module ycc_sync_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        out_valid, out_is_cr, out_active, out_field, out_vblank, out_hs, out_err;
    logic [7:0]  out_luma, out_chroma;

    ycc_sync_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_luma(out_luma), .out_chroma(out_chroma),
        .out_is_cr(out_is_cr), .out_active(out_active), .out_field(out_field),
        .out_vblank(out_vblank), .out_hs(out_hs), .out_err(out_err)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int hs_seen = 0;
    int hs_exp = 0;
    bit done = 1'b0;
    logic [19:0] sb[$];
    // model state
    bit m_act = 0, m_fld = 0, m_vb = 0, m_ph = 0, m_err = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic put_word(input logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Driver: push the expected pixel and send it.
    task automatic pix(input logic [7:0] y, input logic [7:0] c);
        sb.push_back({y, c, m_ph, m_act, m_fld, m_vb});
        m_ph = ~m_ph;
        put_word({y, c});
    endtask

    // Driver: send a two-word code and update the model.
    task automatic code(input logic [7:0] s);
        if (m_ph) m_err = 1;
        put_word(16'h00FF);
        put_word({s, 8'h00});
        m_fld = s[6];
        m_vb  = s[5];
        if (s[4]) begin
            m_act = 0;
            hs_exp++;
        end else begin
            m_act = ~s[5];
        end
        m_ph = 0;
    endtask

    // Monitor: pop and compare every emitted pixel.
    always @(negedge clk) begin
        if (rst_n && out_hs) hs_seen++;
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R3 unexpected pixel", out_luma, 0);
            end else begin
                logic [19:0] e;
                e = sb.pop_front();
                chk({out_luma, out_chroma} == e[19:4], "R1 data", {out_luma, out_chroma}, e[19:4]);
                chk(out_is_cr == e[3], "R2 phase", out_is_cr, e[3]);
                chk(out_active == e[2], "R7 active", out_active, e[2]);
                chk(out_field == e[1], "R4 field", out_field, e[1]);
                chk(out_vblank == e[0], "R5 vblank", out_vblank, e[0]);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        chk({out_valid, out_active, out_field, out_vblank, out_hs, out_err} == 6'b0,
            "R11 reset outputs", {out_valid, out_active, out_field, out_vblank, out_hs, out_err}, 0);
        rst_n = 1'b1;
        // R8: SAV in blanking with junk bits 7 and 3..0 set
        code(8'hAF);
        idle(2);
        chk(out_field == 1'b0 && out_vblank == 1'b1 && out_active == 1'b0,
            "R8 ignored bits", {out_field, out_vblank, out_active}, 3'b010);
        pix(8'h10, 8'h80); pix(8'h11, 8'h81); pix(8'h12, 8'h82); pix(8'h13, 8'h83);
        code(8'h30);                        // R6 EAV in blanking
        pix(8'h20, 8'h90); pix(8'h21, 8'h91);
        code(8'h00);                        // R7 SAV active
        pix(8'hA0, 8'h40); pix(8'hA1, 8'h41); pix(8'hA2, 8'h42);
        idle(3);                            // R1 stall while held
        pix(8'hA3, 8'h43); pix(8'hA4, 8'h44); pix(8'hA5, 8'h45);
        pix(8'h00, 8'hFF); pix(8'h55, 8'h66); // R9 false marker
        code(8'h9F);                        // R6 EAV, R8 junk bits
        code(8'h40);                        // R4 field 2 SAV
        pix(8'hB0, 8'h10); pix(8'hB1, 8'h11); pix(8'hB2, 8'h12);
        idle(2);
        chk(out_err == 1'b0, "R10 no error yet", out_err, 0);
        code(8'h50);                        // R10 code on Cr slot
        idle(2);
        chk(out_err == 1'b1, "R10 error set", out_err, 1);
        code(8'h60);                        // R5 blanking SAV
        pix(8'hC0, 8'h20); pix(8'hC1, 8'h21);
        idle(6);
        chk(out_err == 1'b1, "R10 error sticky", out_err, 1);
        chk(hs_seen == hs_exp, "R6 hs pulses", hs_seen, hs_exp);
        chk(sb.size() == 1, "R3 pixel count", sb.size(), 1);
        chk(out_active == 1'b0 && out_field == 1'b1 && out_vblank == 1'b1,
            "R5 final flags", {out_active, out_field, out_vblank}, 3'b011);
        done = 1'b1;
        summary();
    end
endmodule